// File: doc/BRIEF.md
# Queue-Port Request Mailbox

This block is the device-side register window that a host uses to exchange work with a storage controller's firmware. The host talks to it over a 32-bit register bus. A read of the inbound queue port hands out the offset of a free request slot in controller memory. A write to the same port posts a request. The posted value is either one of those slot offsets, or a host-memory request written as bit 31 set OR'd with its 32-byte-aligned bus address shifted right by five. The firmware side drains posted requests and pushes completions into an outbound queue. The host reads completions from the outbound queue port, and hands controller-memory slots back to the free pool by writing their offsets to that same port.

Non-queued commands use message registers. The host writes an inbound message, and the firmware signals that the command is done by writing the same value into the outbound message register. Two interrupt paths exist. Host doorbell writes raise a masked interrupt toward the firmware. A non-empty outbound queue, or a new outbound message, raises a masked interrupt toward the host.

Register offsets (byte addresses): inbound message 0 `0x10`, inbound message 1 `0x14`, outbound message 0 `0x18`, outbound message 1 `0x1C`, doorbell `0x20`, inbound status `0x24`, inbound mask `0x28`, outbound status `0x30`, outbound mask `0x34`, inbound queue port `0x40`, outbound queue port `0x44`. Other addresses read as zero.

Top module: `qport_mailbox`

## Requirements
- R1: Out of reset, the free pool holds N_SLOTS offsets, SLOT_BASE + i*SLOT_STEP for i = 0 upward. Successive reads of `0x40` return them in ascending order, and once the pool is empty they return 0xFFFFFFFF.
- R2: A host write to `0x40` enqueues the written value unchanged, including values with bit 31 set. The firmware sees the values at `lc_post_data`, with `lc_post_valid` high, in write order, and `lc_post_pop` removes the head.
- R3: A firmware completion push stores `lc_cmpl_ctx` when `lc_cmpl_tag[31]` is 1 and `lc_cmpl_ctx_en` is 1. In every other case it stores `lc_cmpl_tag`.
- R4: Reads of `0x44` return outbound entries in push order. A read of an empty outbound queue returns 0xFFFFFFFF.
- R5: A host write to `0x44` returns the value to the tail of the free pool, and later reads of `0x40` hand it out.
- R6: Host writes to `0x10` and `0x14` appear on `lc_imsg0` and `lc_imsg1`. A write to `0x10` pulses `lc_imsg_stb` for the one cycle after the write edge. Firmware writes with `lc_omsg_sel` = 0 or 1 are read back at `0x18` or `0x1C`.
- R7: Outbound status bit 0 is 1 exactly while the outbound queue is non-empty. Bit 1 is set by a firmware outbound message write and cleared when the host writes 1 to bit 1 of `0x30`. If both happen in the same cycle, the set wins.
- R8: `host_irq` is the OR of the outbound status bits [1:0] ANDed with the inverse of outbound mask bits [1:0]. The mask at `0x34` resets to 0x3.
- R9: A host write to `0x20` ORs its low DB_BITS into the inbound status, which is readable at `0x24`. `lc_irq` is the OR of the inbound status ANDed with the inverse of the mask at `0x28`, which resets to 0. `lc_istat_clr` clears status bits by writing 1s.
- R10: A push into a full post queue or a full outbound queue is dropped, and the existing entries are kept.
- R11: A host read of `0x44` and a firmware completion push in the same cycle both take effect. This holds even when the queue is empty.
- R12: Read data appears on `hb_rdata` on the clock edge that samples `hb_rd`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_wr | input | 1 | Host register write strobe |
| hb_rd | input | 1 | Host register read strobe |
| hb_addr | input | 8 | Host byte address |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Registered host read data |
| host_irq | output | 1 | Interrupt toward the host |
| lc_post_valid | output | 1 | A posted request is waiting |
| lc_post_data | output | 32 | Oldest posted request value |
| lc_post_pop | input | 1 | Firmware consumes the posted head |
| lc_cmpl_push | input | 1 | Firmware pushes a completion |
| lc_cmpl_tag | input | 32 | Posted value of the completed request |
| lc_cmpl_ctx_en | input | 1 | Request asked for its context value to be returned |
| lc_cmpl_ctx | input | 32 | Low 32 bits of the request context |
| lc_imsg0 | output | 32 | Inbound message 0 |
| lc_imsg1 | output | 32 | Inbound message 1 |
| lc_imsg_stb | output | 1 | Pulse after a host write of inbound message 0 |
| lc_omsg_wr | input | 1 | Firmware writes an outbound message |
| lc_omsg_sel | input | 1 | Outbound message select (0 or 1) |
| lc_omsg_data | input | 32 | Outbound message value |
| lc_istat | output | DB_BITS | Inbound doorbell status |
| lc_istat_clr | input | DB_BITS | Write-1-to-clear of inbound status |
| lc_irq | output | 1 | Interrupt toward the firmware |

## Verification
The collision that matters most is a host read of the outbound queue port landing in the same cycle as a firmware completion push. The bench provokes it twice. In one case the queue holds one entry, and the read must return that entry while the new one stays queued. In the other case the queue is empty, and the read must return 0xFFFFFFFF while the pushed entry is kept for the next read. The bench also collides a host write-1-to-clear of the outbound message flag with a firmware outbound message write, and expects the flag to remain set.

// File: rtl/qpm_pkg.sv
// Shared constants for the queue-port mailbox: register byte offsets
// and the sentinel returned when a queue port has nothing to give.
package qpm_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_IMSG0  = 8'h10;
    localparam logic [ADDR_W-1:0] A_IMSG1  = 8'h14;
    localparam logic [ADDR_W-1:0] A_OMSG0  = 8'h18;
    localparam logic [ADDR_W-1:0] A_OMSG1  = 8'h1C;
    localparam logic [ADDR_W-1:0] A_DBELL  = 8'h20;
    localparam logic [ADDR_W-1:0] A_ISTAT  = 8'h24;
    localparam logic [ADDR_W-1:0] A_IMASK  = 8'h28;
    localparam logic [ADDR_W-1:0] A_OSTAT  = 8'h30;
    localparam logic [ADDR_W-1:0] A_OMASK  = 8'h34;
    localparam logic [ADDR_W-1:0] A_INQ    = 8'h40;
    localparam logic [ADDR_W-1:0] A_OUTQ   = 8'h44;

    localparam logic [DATA_W-1:0] EMPTY_WORD = 32'hFFFF_FFFF;
    localparam int HOST_REQ_BIT = 31;

    // Outbound status bit positions
    localparam int OST_NONEMPTY = 0;
    localparam int OST_MSG      = 1;
endpackage

// File: rtl/qpm_fifo.sv
// Synchronous FIFO with a combinational head output.
// Assumes: push and pop may happen in the same cycle. A push into a full
// FIFO is dropped unless a pop frees room in that same cycle. When PRELOAD
// is set, reset fills every entry with BASE + i*STEP, so the FIFO starts full.
module qpm_fifo #(
    parameter int              W       = 32,
    parameter int              DEPTH   = 4,
    parameter bit              PRELOAD = 1'b0,
    parameter logic [W-1:0]    BASE    = '0,
    parameter logic [W-1:0]    STEP    = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH-1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    // Storage: reset preload or write at the tail
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= PRELOAD ? (BASE + STEP * W'(i)) : '0;
            end
        end else if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= PRELOAD ? CW'(DEPTH) : '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/qpm_msg.sv
// Message registers for non-queued commands. The host writes two inbound
// messages; the firmware writes two outbound messages. A write of inbound
// message 0 produces a one-cycle strobe toward the firmware.
// Assumes: the firmware answers a command by writing the same value to
// outbound message 0, and the host compares the two values.
module qpm_msg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         imsg0_wr,
    input  logic         imsg1_wr,
    input  logic [W-1:0] host_wdata,
    input  logic         omsg_wr,
    input  logic         omsg_sel,
    input  logic [W-1:0] omsg_data,
    output logic [W-1:0] imsg0,
    output logic [W-1:0] imsg1,
    output logic [W-1:0] omsg0,
    output logic [W-1:0] omsg1,
    output logic         imsg_stb
);
    // Inbound messages and the command strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imsg0    <= '0;
            imsg1    <= '0;
            imsg_stb <= 1'b0;
        end else begin
            if (imsg0_wr) imsg0 <= host_wdata;
            if (imsg1_wr) imsg1 <= host_wdata;
            imsg_stb <= imsg0_wr;
        end
    end

    // Outbound messages written by the firmware
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            omsg0 <= '0;
            omsg1 <= '0;
        end else if (omsg_wr) begin
            if (omsg_sel) omsg1 <= omsg_data;
            else          omsg0 <= omsg_data;
        end
    end
endmodule

// File: rtl/qpm_irq.sv
// Interrupt status and mask for both directions.
// The inbound side collects doorbell bits, which the firmware clears by
// writing 1s. The outbound side has two bits: a live queue-non-empty flag
// and a sticky message flag that the host clears by writing 1. A set in the
// same cycle as a clear wins.
module qpm_irq #(
    parameter int DB_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dbell_wr,
    input  logic               imask_wr,
    input  logic               ostat_wr,
    input  logic               omask_wr,
    input  logic [31:0]        host_wdata,
    input  logic [DB_BITS-1:0] istat_clr,
    input  logic               omsg_evt,
    input  logic               ob_nonempty,
    output logic [DB_BITS-1:0] istat,
    output logic [DB_BITS-1:0] imask,
    output logic [1:0]         ostat,
    output logic [1:0]         omask,
    output logic               host_irq,
    output logic               lc_irq
);
    logic               omsg_flag;
    logic [DB_BITS-1:0] db_set;

    assign db_set = dbell_wr ? host_wdata[DB_BITS-1:0] : '0;

    // Inbound doorbell status: set from the host, cleared by the firmware
    always_ff @(posedge clk) begin
        if (!rst_n) istat <= '0;
        else        istat <= (istat & ~istat_clr) | db_set;
    end

    // Masks for both directions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask <= '0;
            omask <= 2'b11;
        end else begin
            if (imask_wr) imask <= host_wdata[DB_BITS-1:0];
            if (omask_wr) omask <= host_wdata[1:0];
        end
    end

    // Sticky outbound message flag, write-1-to-clear, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)                                        omsg_flag <= 1'b0;
        else if (omsg_evt)                                 omsg_flag <= 1'b1;
        else if (ostat_wr && host_wdata[qpm_pkg::OST_MSG]) omsg_flag <= 1'b0;
    end

    assign ostat    = {omsg_flag, ob_nonempty};
    assign host_irq = |(ostat & ~omask);
    assign lc_irq   = |(istat & ~imask);
endmodule

// File: rtl/qport_mailbox.sv
// Top of the queue-port mailbox. Decodes the host register bus, owns the
// three queues (free slots, posted requests, completions), and builds the
// registered read data.
// Assumes: hb_wr and hb_rd are never high together; a queue-port read with
// nothing to return yields the all-ones word.
module qport_mailbox
    import qpm_pkg::*;
#(
    parameter int              N_SLOTS    = 8,
    parameter logic [31:0]     SLOT_BASE  = 32'h0000_1000,
    parameter logic [31:0]     SLOT_STEP  = 32'h0000_0100,
    parameter int              POST_DEPTH = 4,
    parameter int              OB_DEPTH   = 4,
    parameter int              DB_BITS    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hb_wr,
    input  logic               hb_rd,
    input  logic [7:0]         hb_addr,
    input  logic [31:0]        hb_wdata,
    output logic [31:0]        hb_rdata,
    output logic               host_irq,
    output logic               lc_post_valid,
    output logic [31:0]        lc_post_data,
    input  logic               lc_post_pop,
    input  logic               lc_cmpl_push,
    input  logic [31:0]        lc_cmpl_tag,
    input  logic               lc_cmpl_ctx_en,
    input  logic [31:0]        lc_cmpl_ctx,
    output logic [31:0]        lc_imsg0,
    output logic [31:0]        lc_imsg1,
    output logic               lc_imsg_stb,
    input  logic               lc_omsg_wr,
    input  logic               lc_omsg_sel,
    input  logic [31:0]        lc_omsg_data,
    output logic [DB_BITS-1:0] lc_istat,
    input  logic [DB_BITS-1:0] lc_istat_clr,
    output logic               lc_irq
);
    localparam int FREE_CW = $clog2(N_SLOTS+1);
    localparam int POST_CW = $clog2(POST_DEPTH+1);
    localparam int OB_CW   = $clog2(OB_DEPTH+1);

    // Address decode
    logic wr_inq, wr_outq, rd_inq, rd_outq;
    assign wr_inq  = hb_wr && (hb_addr == A_INQ);
    assign wr_outq = hb_wr && (hb_addr == A_OUTQ);
    assign rd_inq  = hb_rd && (hb_addr == A_INQ);
    assign rd_outq = hb_rd && (hb_addr == A_OUTQ);

    // Free-slot pool, preloaded at reset
    logic [31:0]        free_head;
    logic               free_empty, free_full;
    logic [FREE_CW-1:0] free_count;

    qpm_fifo #(.W(32), .DEPTH(N_SLOTS), .PRELOAD(1'b1),
               .BASE(SLOT_BASE), .STEP(SLOT_STEP)) u_free (
        .clk(clk), .rst_n(rst_n),
        .push(wr_outq), .din(hb_wdata),
        .pop(rd_inq), .dout(free_head),
        .empty(free_empty), .full(free_full), .count(free_count)
    );

    // Posted-request queue toward the firmware
    logic               post_empty, post_full;
    logic [POST_CW-1:0] post_count;

    qpm_fifo #(.W(32), .DEPTH(POST_DEPTH)) u_post (
        .clk(clk), .rst_n(rst_n),
        .push(wr_inq), .din(hb_wdata),
        .pop(lc_post_pop), .dout(lc_post_data),
        .empty(post_empty), .full(post_full), .count(post_count)
    );
    assign lc_post_valid = !post_empty;

    // Completion queue toward the host; context substitution for host-memory requests
    logic [31:0]      ob_din, ob_head;
    logic             ob_empty, ob_full;
    logic [OB_CW-1:0] ob_count;

    assign ob_din = (lc_cmpl_tag[HOST_REQ_BIT] && lc_cmpl_ctx_en) ? lc_cmpl_ctx : lc_cmpl_tag;

    qpm_fifo #(.W(32), .DEPTH(OB_DEPTH)) u_outq (
        .clk(clk), .rst_n(rst_n),
        .push(lc_cmpl_push), .din(ob_din),
        .pop(rd_outq), .dout(ob_head),
        .empty(ob_empty), .full(ob_full), .count(ob_count)
    );

    // Message registers
    logic [31:0] omsg0, omsg1;

    qpm_msg #(.W(32)) u_msg (
        .clk(clk), .rst_n(rst_n),
        .imsg0_wr(hb_wr && (hb_addr == A_IMSG0)),
        .imsg1_wr(hb_wr && (hb_addr == A_IMSG1)),
        .host_wdata(hb_wdata),
        .omsg_wr(lc_omsg_wr), .omsg_sel(lc_omsg_sel), .omsg_data(lc_omsg_data),
        .imsg0(lc_imsg0), .imsg1(lc_imsg1),
        .omsg0(omsg0), .omsg1(omsg1),
        .imsg_stb(lc_imsg_stb)
    );

    // Interrupt status and masks
    logic [DB_BITS-1:0] imask;
    logic [1:0]         ostat, omask;

    qpm_irq #(.DB_BITS(DB_BITS)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .dbell_wr(hb_wr && (hb_addr == A_DBELL)),
        .imask_wr(hb_wr && (hb_addr == A_IMASK)),
        .ostat_wr(hb_wr && (hb_addr == A_OSTAT)),
        .omask_wr(hb_wr && (hb_addr == A_OMASK)),
        .host_wdata(hb_wdata),
        .istat_clr(lc_istat_clr),
        .omsg_evt(lc_omsg_wr),
        .ob_nonempty(!ob_empty),
        .istat(lc_istat), .imask(imask),
        .ostat(ostat), .omask(omask),
        .host_irq(host_irq), .lc_irq(lc_irq)
    );

    // Read mux for the host bus
    logic [31:0] rd_mux;
    always_comb begin
        case (hb_addr)
            A_IMSG0: rd_mux = lc_imsg0;
            A_IMSG1: rd_mux = lc_imsg1;
            A_OMSG0: rd_mux = omsg0;
            A_OMSG1: rd_mux = omsg1;
            A_ISTAT: rd_mux = 32'(lc_istat);
            A_IMASK: rd_mux = 32'(imask);
            A_OSTAT: rd_mux = 32'(ostat);
            A_OMASK: rd_mux = 32'(omask);
            A_INQ:   rd_mux = free_empty ? EMPTY_WORD : free_head;
            A_OUTQ:  rd_mux = ob_empty ? EMPTY_WORD : ob_head;
            default: rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)     hb_rdata <= '0;
        else if (hb_rd) hb_rdata <= rd_mux;
    end
endmodule

// File: rtl/qport_mailbox_chk.sv
// Assertion checker for the queue-port mailbox, attached by bind.
// Observes host bus, interrupt outputs and queue occupancies.
module qport_mailbox_chk #(
    parameter int N_SLOTS  = 8,
    parameter int OB_DEPTH = 4,
    parameter int POST_DEPTH = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           hb_wr,
    input logic                           hb_rd,
    input logic [7:0]                     hb_addr,
    input logic [31:0]                    hb_rdata,
    input logic                           host_irq,
    input logic [1:0]                     omask,
    input logic                           lc_omsg_wr,
    input logic                           lc_imsg_stb,
    input logic                           lc_cmpl_push,
    input logic [$clog2(OB_DEPTH+1)-1:0]  ob_count,
    input logic [$clog2(N_SLOTS+1)-1:0]   free_count,
    input logic [$clog2(POST_DEPTH+1)-1:0] post_count
);
    // R4: an outbound read with no entries and no same-cycle push yields all ones
    assert_outq_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_rd && hb_addr == 8'h44 && ob_count == 0) |=> (hb_rdata == 32'hFFFF_FFFF));

    // R1: free-pool read with an empty pool yields all ones
    assert_inq_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_rd && hb_addr == 8'h40 && free_count == 0) |=> (hb_rdata == 32'hFFFF_FFFF));

    // R8: unmasked non-empty queue raises the host interrupt
    assert_irq_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_count != 0 && !omask[0]) |-> host_irq);

    // R8: fully masked outbound side keeps the host interrupt low
    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (omask == 2'b11) |-> !host_irq);

    // R7: a firmware message write is visible as an unmasked interrupt next cycle
    assert_msg_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_omsg_wr && !hb_wr && !omask[1]) |=> host_irq);

    // R6: inbound message 0 write produces the strobe on the next cycle
    assert_imsg_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_wr && hb_addr == 8'h10) |=> lc_imsg_stb);

    // R10: occupancies never exceed their depths
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_count <= OB_DEPTH) && (post_count <= POST_DEPTH) && (free_count <= N_SLOTS));

    // R12: read data holds while no read is issued
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!hb_rd && $past(rst_n)) |=> $stable(hb_rdata));
endmodule

bind qport_mailbox qport_mailbox_chk #(
    .N_SLOTS(N_SLOTS), .OB_DEPTH(OB_DEPTH), .POST_DEPTH(POST_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_addr(hb_addr), .hb_rdata(hb_rdata),
    .host_irq(host_irq), .omask(omask),
    .lc_omsg_wr(lc_omsg_wr), .lc_imsg_stb(lc_imsg_stb), .lc_cmpl_push(lc_cmpl_push),
    .ob_count(ob_count), .free_count(free_count), .post_count(post_count)
);

// File: tb/qport_mailbox_tb.sv
// Directed bench for the queue-port mailbox: one task per scenario.
module qport_mailbox_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hb_wr = 0, hb_rd = 0;
    logic [7:0]    hb_addr = 0;
    logic [31:0]   hb_wdata = 0;
    logic [31:0]   hb_rdata;
    logic          host_irq;
    logic          lc_post_valid;
    logic [31:0]   lc_post_data;
    logic          lc_post_pop = 0;
    logic          lc_cmpl_push = 0;
    logic [31:0]   lc_cmpl_tag = 0;
    logic          lc_cmpl_ctx_en = 0;
    logic [31:0]   lc_cmpl_ctx = 0;
    logic [31:0]   lc_imsg0, lc_imsg1;
    logic          lc_imsg_stb;
    logic          lc_omsg_wr = 0, lc_omsg_sel = 0;
    logic [31:0]   lc_omsg_data = 0;
    logic [DB-1:0] lc_istat;
    logic [DB-1:0] lc_istat_clr = 0;
    logic          lc_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qport_mailbox u_dut (
        .clk(clk), .rst_n(rst_n),
        .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
        .hb_rdata(hb_rdata), .host_irq(host_irq),
        .lc_post_valid(lc_post_valid), .lc_post_data(lc_post_data), .lc_post_pop(lc_post_pop),
        .lc_cmpl_push(lc_cmpl_push), .lc_cmpl_tag(lc_cmpl_tag),
        .lc_cmpl_ctx_en(lc_cmpl_ctx_en), .lc_cmpl_ctx(lc_cmpl_ctx),
        .lc_imsg0(lc_imsg0), .lc_imsg1(lc_imsg1), .lc_imsg_stb(lc_imsg_stb),
        .lc_omsg_wr(lc_omsg_wr), .lc_omsg_sel(lc_omsg_sel), .lc_omsg_data(lc_omsg_data),
        .lc_istat(lc_istat), .lc_istat_clr(lc_istat_clr), .lc_irq(lc_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Host write: one edge, returns at the following falling edge
    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        hb_wr = 1; hb_addr = a; hb_wdata = d;
        @(negedge clk);
        hb_wr = 0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        hb_rd = 1; hb_addr = a;
        @(negedge clk);
        hb_rd = 0;
        d = hb_rdata;
    endtask

    task automatic cpush(input logic [31:0] tag, input logic ce, input logic [31:0] ctx);
        lc_cmpl_push = 1; lc_cmpl_tag = tag; lc_cmpl_ctx_en = ce; lc_cmpl_ctx = ctx;
        @(negedge clk);
        lc_cmpl_push = 0; lc_cmpl_ctx_en = 0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R8 reset host_irq", 32'(host_irq), 0);
        check("R9 reset lc_irq", 32'(lc_irq), 0);
        check("R2 reset post_valid", 32'(lc_post_valid), 0);
        hread(8'h34, r); check("R8 omask reset", r, 32'h3);
        hread(8'h30, r); check("R7 ostat reset", r, 32'h0);
        hread(8'h28, r); check("R9 imask reset", r, 32'h0);
        hread(8'h50, r); check("R12 unmapped reads zero", r, 32'h0);
    endtask

    task automatic t_free_pool();
        logic [31:0] r;
        for (int i = 0; i < 8; i++) begin
            hread(8'h40, r); check("R1 free slot order", r, 32'h1000 + 32'(i) * 32'h100);
        end
        hread(8'h40, r); check("R1 empty pool", r, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        check("R12 rdata holds", hb_rdata, 32'hFFFF_FFFF);
    endtask

    task automatic t_recycle();
        logic [31:0] r;
        hwrite(8'h44, 32'h1300);
        hwrite(8'h44, 32'h1100);
        check("R5 outq write not a completion", 32'(host_irq), 0);
        hread(8'h40, r); check("R5 recycled first", r, 32'h1300);
        hread(8'h40, r); check("R5 recycled second", r, 32'h1100);
        hread(8'h40, r); check("R5 pool empty again", r, 32'hFFFF_FFFF);
    endtask

    task automatic t_post();
        hwrite(8'h40, 32'h1200);
        hwrite(8'h40, 32'h8000_0000 | (32'h1234_5660 >> 5));
        check("R2 post valid", 32'(lc_post_valid), 1);
        check("R2 post head local", lc_post_data, 32'h1200);
        lc_post_pop = 1; @(negedge clk); lc_post_pop = 0;
        check("R2 post head host", lc_post_data, 32'h8091_A2B3);
        lc_post_pop = 1; @(negedge clk); lc_post_pop = 0;
        check("R2 post drained", 32'(lc_post_valid), 0);
        for (int i = 0; i < 5; i++) hwrite(8'h40, 32'hA0 + 32'(i));
        for (int i = 0; i < 4; i++) begin
            check("R10 post full kept", lc_post_data, 32'hA0 + 32'(i));
            lc_post_pop = 1; @(negedge clk); lc_post_pop = 0;
        end
        check("R10 post overflow dropped", 32'(lc_post_valid), 0);
    endtask

    task automatic t_complete();
        logic [31:0] r;
        cpush(32'h1200, 1, 32'hDEAD_BEEF);
        cpush(32'h8091_A2B3, 0, 32'h1111_1111);
        cpush(32'h8091_A2B3, 1, 32'hCAFE_0001);
        hread(8'h30, r); check("R7 nonempty bit", r, 32'h1);
        check("R8 masked no irq", 32'(host_irq), 0);
        hwrite(8'h34, 32'h2);
        check("R8 unmasked queue irq", 32'(host_irq), 1);
        hread(8'h44, r); check("R3 local tag kept", r, 32'h1200);
        hread(8'h44, r); check("R3 host tag no ctx", r, 32'h8091_A2B3);
        hread(8'h44, r); check("R3 ctx substituted", r, 32'hCAFE_0001);
        hread(8'h44, r); check("R4 empty outq", r, 32'hFFFF_FFFF);
        check("R7 irq drops when empty", 32'(host_irq), 0);
        for (int i = 1; i <= 5; i++) cpush(32'(i), 0, 0);
        for (int i = 1; i <= 4; i++) begin
            hread(8'h44, r); check("R10 outq full kept", r, 32'(i));
        end
        hread(8'h44, r); check("R10 outq overflow dropped", r, 32'hFFFF_FFFF);
    endtask

    task automatic t_same_cycle();
        logic [31:0] r;
        cpush(32'h0000_0A0A, 0, 0);
        hb_rd = 1; hb_addr = 8'h44;
        lc_cmpl_push = 1; lc_cmpl_tag = 32'h0000_0B0B;
        @(negedge clk);
        hb_rd = 0; lc_cmpl_push = 0;
        check("R11 pop returns older", hb_rdata, 32'h0000_0A0A);
        hread(8'h44, r); check("R11 push kept", r, 32'h0000_0B0B);
        // empty queue: read and push together
        hb_rd = 1; hb_addr = 8'h44;
        lc_cmpl_push = 1; lc_cmpl_tag = 32'h0000_0C0C;
        @(negedge clk);
        hb_rd = 0; lc_cmpl_push = 0;
        check("R11 empty collide read", hb_rdata, 32'hFFFF_FFFF);
        hread(8'h44, r); check("R11 empty collide kept", r, 32'h0000_0C0C);
    endtask

    task automatic t_msg();
        logic [31:0] r;
        hb_wr = 1; hb_addr = 8'h10; hb_wdata = 32'h55;
        @(negedge clk); hb_wr = 0;
        check("R6 imsg0", lc_imsg0, 32'h55);
        check("R6 strobe high", 32'(lc_imsg_stb), 1);
        @(negedge clk);
        check("R6 strobe one cycle", 32'(lc_imsg_stb), 0);
        hwrite(8'h14, 32'h66);
        check("R6 imsg1", lc_imsg1, 32'h66);
        check("R6 imsg1 no strobe", 32'(lc_imsg_stb), 0);
        lc_omsg_wr = 1; lc_omsg_sel = 0; lc_omsg_data = 32'h55;
        @(negedge clk);
        lc_omsg_sel = 1; lc_omsg_data = 32'h77;
        @(negedge clk); lc_omsg_wr = 0;
        hread(8'h18, r); check("R6 omsg0 matches", r, 32'h55);
        hread(8'h1C, r); check("R6 omsg1", r, 32'h77);
        hread(8'h30, r); check("R7 msg flag", r, 32'h2);
        check("R8 msg masked", 32'(host_irq), 0);
        hwrite(8'h34, 32'h0);
        check("R8 msg irq", 32'(host_irq), 1);
        hwrite(8'h30, 32'h1);
        hread(8'h30, r); check("R7 w1c other bit no effect", r, 32'h2);
        hwrite(8'h30, 32'h2);
        hread(8'h30, r); check("R7 w1c clears", r, 32'h0);
        check("R8 irq cleared", 32'(host_irq), 0);
        hb_wr = 1; hb_addr = 8'h30; hb_wdata = 32'h2;
        lc_omsg_wr = 1; lc_omsg_sel = 0; lc_omsg_data = 32'h88;
        @(negedge clk); hb_wr = 0; lc_omsg_wr = 0;
        hread(8'h30, r); check("R7 set beats clear", r, 32'h2);
        hwrite(8'h30, 32'h2);
    endtask

    task automatic t_doorbell();
        logic [31:0] r;
        hwrite(8'h20, 32'h05);
        hread(8'h24, r); check("R9 status set", r, 32'h05);
        check("R9 lc_irq", 32'(lc_irq), 1);
        hwrite(8'h20, 32'h08);
        hread(8'h24, r); check("R9 status ors", r, 32'h0D);
        hwrite(8'h28, 32'h0D);
        check("R9 masked", 32'(lc_irq), 0);
        hwrite(8'h28, 32'h00);
        lc_istat_clr = 8'h09; @(negedge clk); lc_istat_clr = 0;
        check("R9 w1c", 32'(lc_istat), 32'h04);
        lc_istat_clr = 8'h04; @(negedge clk); lc_istat_clr = 0;
        check("R9 all clear", 32'(lc_irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_free_pool();
        t_recycle();
        t_post();
        t_complete();
        t_same_cycle();
        t_msg();
        t_doorbell();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule